// File: doc/BRIEF.md
# Mesh Router Input Port with Virtual Channels

This block is one input port of a wormhole router in a two-dimensional mesh. Flits arrive over a valid/ready handshake. Each flit carries a virtual-channel number and a head marker, and it is stored in the FIFO of its channel. Every channel has its own ready line, so a full channel stalls only the senders that use that channel.

When a head flit reaches the front of its channel, the block decodes the destination coordinates and the packet length from it. It then computes the output direction using dimension-order routing, either row first or column first, chosen at compile time. The chosen direction stays locked for that channel until the packet's last flit has been forwarded. Each cycle the block offers at most one flit to the switch. It picks the highest-priority channel whose front flit has a direction that is ready downstream. The priority direction is a parameter.

Head flit layout: bits [7:0] hold the packet length minus one (1 to 256 flits), bits [8 +: column width] hold the destination column, and bits [16 +: row width] hold the destination row. Direction codes: 0 local, 1 north (smaller row), 2 south (larger row), 3 east (larger column), 4 west (smaller column). `out_ready` is indexed by these codes.

Top module: `rtr_input_unit`

## Requirements
- R1: `in_ready[v]` is low exactly while channel v holds `FIFO_DEPTH` flits. A flit is taken only when `in_valid` is high and `in_ready[in_vc]` is high, and no accepted flit is ever lost.
- R2: Within one channel, flits leave in the order in which they were accepted, with their data unchanged.
- R3: With row-first routing, a head flit is sent north or south until its row matches the router's row, then east or west until its column matches, and local when both match. The direction codes are 0 local, 1 north, 2 south, 3 east, 4 west.
- R4: With column-first routing (`ROUTE_YX`=1), the column is corrected first and the row second, using the same codes.
- R5: Body and tail flits leave on the direction that the head of their packet locked, whatever their data holds. The packet is `head[7:0]`+1 flits long (up to 256). `out_tail` marks its last flit, after which the next head is routed afresh. `out_head` marks head flits.
- R6: A channel is offered only when its FIFO is non-empty and `out_ready` is high for its direction. `out_valid` is low when no channel qualifies, and a flit leaves in every cycle in which `out_valid` is high.
- R7: With `VC0_HIGH`=1, the lowest-numbered qualifying channel wins.
- R8: With `VC0_HIGH`=0, the highest-numbered qualifying channel wins.
- R9: After reset all channels are empty, `out_valid` is low and every `in_ready` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming flit valid |
| in_vc | input | VCW | Channel of the incoming flit |
| in_head | input | 1 | Incoming flit is a packet head |
| in_data | input | FLIT_W | Incoming flit payload |
| in_ready | output | N_VC | Per-channel space available |
| out_valid | output | 1 | A flit is forwarded this cycle |
| out_vc | output | VCW | Channel of the forwarded flit |
| out_dir | output | 3 | Output direction code |
| out_head | output | 1 | Forwarded flit is a head |
| out_tail | output | 1 | Forwarded flit ends its packet |
| out_data | output | FLIT_W | Forwarded flit payload |
| out_ready | input | 5 | Downstream ready, one bit per direction code |

## Verification
Some properties are checked on every cycle by the assertions. No FIFO is written while full and no occupancy exceeds the depth. The grant is one-hot and only goes to a qualifying channel. A forwarded flit always has a legal direction that is ready downstream. A body flit is never forwarded outside a locked packet. Other behaviours can only be shown by the bench's scenarios, which compare the outputs against a per-channel scoreboard. These are the routing results for every destination under both orders, the winner under each priority direction, the route that a head locks for its packet's body flits (including a 256-flit packet), and the stall and recovery of a full channel.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_SOUTH = 3'd2,
    DIR_EAST  = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  localparam int N_DIRS  = 5;
  localparam int LEN_W   = 8;
  localparam int COL_LSB = 8;
  localparam int ROW_LSB = 16;

  function automatic dir_e row_step(int dst, int own);
    if (dst < own) return DIR_NORTH;
    if (dst > own) return DIR_SOUTH;
    return DIR_LOCAL;
  endfunction

  function automatic dir_e col_step(int dst, int own);
    if (dst > own) return DIR_EAST;
    if (dst < own) return DIR_WEST;
    return DIR_LOCAL;
  endfunction

  // Dimension-order route: the first dimension that still differs wins.
  function automatic dir_e route_dir(int dst_row, int dst_col, int own_row, int own_col,
                                     bit col_first);
    dir_e first_d, second_d;
    if (col_first) begin
      first_d  = col_step(dst_col, own_col);
      second_d = row_step(dst_row, own_row);
    end else begin
      first_d  = row_step(dst_row, own_row);
      second_d = col_step(dst_col, own_col);
    end
    return (first_d != DIR_LOCAL) ? first_d : second_d;
  endfunction
endpackage

// File: rtl/rtr_vc_fifo.sv
module rtr_vc_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/rtr_vc_lock.sv
module rtr_vc_lock
  import rtr_pkg::*;
#(
  parameter int FLIT_W   = 32,
  parameter int ROWS     = 2,
  parameter int COLS     = 2,
  parameter int MY_ROW   = 0,
  parameter int MY_COL   = 0,
  parameter bit ROUTE_YX = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLIT_W-1:0] front_data,
  input  logic              front_head,
  input  logic              front_valid,
  input  logic              fwd,
  output logic [2:0]        dir,
  output logic              last
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  logic [2:0]       lock_dir;
  logic [LEN_W-1:0] remain;
  logic             busy;
  dir_e             head_dir;

  always_comb begin
    head_dir = route_dir(int'(front_data[ROW_LSB +: ROW_W]),
                         int'(front_data[COL_LSB +: COL_W]),
                         MY_ROW, MY_COL, ROUTE_YX);
  end

  assign busy = (remain != '0);
  assign dir  = front_head ? head_dir : lock_dir;
  assign last = front_head ? (front_data[LEN_W-1:0] == '0) : (remain == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_dir <= DIR_LOCAL;
      remain   <= '0;
    end else if (fwd) begin
      if (front_head) begin
        lock_dir <= head_dir;
        remain   <= front_data[LEN_W-1:0];
      end else begin
        remain   <= remain - 1'b1;
      end
    end
  end

  // R5
  body_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && !front_head) |-> busy);
  // R6
  fwd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) fwd |-> front_valid);
endmodule

// File: rtl/rtr_vc_arb.sv
module rtr_vc_arb #(
  parameter int N        = 3,
  parameter bit VC0_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    grant = '0;
    any   = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int i;
      i = VC0_HIGH ? k : (N - 1 - k);
      if (!any && elig[i]) begin
        grant[i] = 1'b1;
        any      = 1'b1;
        idx      = IW'(i);
      end
    end
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R6
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~elig) == '0);
endmodule

// File: rtl/rtr_input_unit.sv
module rtr_input_unit
  import rtr_pkg::*;
#(
  parameter int FLIT_W     = 32,
  parameter int N_VC       = 3,
  parameter int FIFO_DEPTH = 2,
  parameter int ROWS       = 2,
  parameter int COLS       = 2,
  parameter int MY_ROW     = 0,
  parameter int MY_COL     = 0,
  parameter bit ROUTE_YX   = 1'b0,
  parameter bit VC0_HIGH   = 1'b1,
  localparam int VCW       = (N_VC > 1) ? $clog2(N_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VCW-1:0]    in_vc,
  input  logic              in_head,
  input  logic [FLIT_W-1:0] in_data,
  output logic [N_VC-1:0]   in_ready,
  output logic              out_valid,
  output logic [VCW-1:0]    out_vc,
  output logic [2:0]        out_dir,
  output logic              out_head,
  output logic              out_tail,
  output logic [FLIT_W-1:0] out_data,
  input  logic [N_DIRS-1:0] out_ready
);
  localparam int ENT_W = FLIT_W + 1;

  logic [N_VC-1:0]   vc_full, vc_empty, vc_push, vc_pop, vc_elig, vc_last, vc_fhead;
  logic [FLIT_W-1:0] vc_fdata [N_VC];
  logic [2:0]        vc_dir   [N_VC];
  logic              win_any;
  logic [VCW-1:0]    win_idx;

  for (genvar v = 0; v < N_VC; v++) begin : g_vc
    logic [ENT_W-1:0] rd;

    assign vc_push[v] = in_valid && (in_vc == VCW'(v)) && !vc_full[v];

    rtr_vc_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (vc_push[v]),
      .wdata ({in_head, in_data}),
      .pop   (vc_pop[v]),
      .rdata (rd),
      .empty (vc_empty[v]),
      .full  (vc_full[v])
    );

    assign vc_fhead[v] = rd[FLIT_W];
    assign vc_fdata[v] = rd[FLIT_W-1:0];

    rtr_vc_lock #(
      .FLIT_W(FLIT_W), .ROWS(ROWS), .COLS(COLS),
      .MY_ROW(MY_ROW), .MY_COL(MY_COL), .ROUTE_YX(ROUTE_YX)
    ) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .front_data  (vc_fdata[v]),
      .front_head  (vc_fhead[v]),
      .front_valid (!vc_empty[v]),
      .fwd         (vc_pop[v]),
      .dir         (vc_dir[v]),
      .last        (vc_last[v])
    );

    assign vc_elig[v] = !vc_empty[v] && out_ready[vc_dir[v]];
  end

  assign in_ready = ~vc_full;

  rtr_vc_arb #(.N(N_VC), .VC0_HIGH(VC0_HIGH)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (vc_elig),
    .grant (vc_pop),
    .any   (win_any),
    .idx   (win_idx)
  );

  always_comb begin
    out_dir  = '0;
    out_head = 1'b0;
    out_tail = 1'b0;
    out_data = '0;
    for (int v = 0; v < N_VC; v++) begin
      if (vc_pop[v]) begin
        out_dir  = vc_dir[v];
        out_head = vc_fhead[v];
        out_tail = vc_last[v];
        out_data = vc_fdata[v];
      end
    end
  end

  assign out_valid = win_any;
  assign out_vc    = win_idx;

  // R3
  out_dir_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dir <= 3'd4));
  // R6
  out_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ready[out_dir]);
endmodule

// File: tb/test_rtr_input_unit.sv
`timescale 1ns/1ps
module test_rtr_input_unit;
  localparam int NV = 3;
  localparam int DEPTH = 2;

  typedef struct packed {
    logic [31:0] d;
    logic [2:0]  dir;
    logic        hd;
    logic        tl;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic sel;
  logic in_valid, in_head;
  logic [1:0] in_vc;
  logic [31:0] in_data;
  logic [4:0] ordy;

  logic [NV-1:0] ia_rdy, ib_rdy;
  logic oa_v, ob_v, oa_h, ob_h, oa_t, ob_t;
  logic [1:0] oa_vc, ob_vc;
  logic [2:0] oa_dir, ob_dir;
  logic [31:0] oa_d, ob_d;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  item_t sq [NV][$];
  logic [2:0] in_dirs [NV];
  logic [7:0] in_rem [NV];

  always #10 clk = ~clk;

  rtr_input_unit #(.FLIT_W(32), .N_VC(NV), .FIFO_DEPTH(DEPTH), .ROWS(3), .COLS(3),
    .MY_ROW(1), .MY_COL(1), .ROUTE_YX(1'b0), .VC0_HIGH(1'b1)) i_rtr_input_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && !sel), .in_vc(in_vc),
    .in_head(in_head), .in_data(in_data), .in_ready(ia_rdy), .out_valid(oa_v),
    .out_vc(oa_vc), .out_dir(oa_dir), .out_head(oa_h), .out_tail(oa_t),
    .out_data(oa_d), .out_ready(ordy));

  rtr_input_unit #(.FLIT_W(32), .N_VC(NV), .FIFO_DEPTH(DEPTH), .ROWS(3), .COLS(3),
    .MY_ROW(1), .MY_COL(1), .ROUTE_YX(1'b1), .VC0_HIGH(1'b0)) i_rtr_input_unit_yx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && sel), .in_vc(in_vc),
    .in_head(in_head), .in_data(in_data), .in_ready(ib_rdy), .out_valid(ob_v),
    .out_vc(ob_vc), .out_dir(ob_dir), .out_head(ob_h), .out_tail(ob_t),
    .out_data(ob_d), .out_ready(ordy));

  wire [NV-1:0] m_rdy = sel ? ib_rdy : ia_rdy;
  wire          m_v   = sel ? ob_v   : oa_v;
  wire [1:0]    m_vc  = sel ? ob_vc  : oa_vc;
  wire [2:0]    m_dir = sel ? ob_dir : oa_dir;
  wire          m_h   = sel ? ob_h   : oa_h;
  wire          m_t   = sel ? ob_t   : oa_t;
  wire [31:0]   m_d   = sel ? ob_d   : oa_d;

  // Own router sits at row 1, column 1: north/south on rows, east/west on columns.
  function automatic logic [2:0] exp_route(int r, int c, bit col_first);
    int dr, dc;
    logic [2:0] rd, cd;
    dr = r - 1;
    dc = c - 1;
    rd = (dr == 0) ? 3'd0 : ((dr > 0) ? 3'd2 : 3'd1);
    cd = (dc == 0) ? 3'd0 : ((dc > 0) ? 3'd3 : 3'd4);
    if (col_first) return (cd != 3'd0) ? cd : rd;
    return (rd != 3'd0) ? rd : cd;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int vc, input bit hd, input logic [31:0] d);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_vc    = 2'(vc);
    in_head  = hd;
    in_data  = d;
    #5;
    while (!m_rdy[vc]) begin
      @(negedge clk);
      #5;
    end
    it.d  = d;
    it.hd = hd;
    if (hd) begin
      it.dir = exp_route(int'(d[23:16]), int'(d[15:8]), sel);
      in_dirs[vc] = it.dir;
      in_rem[vc]  = d[7:0];
    end else begin
      it.dir = in_dirs[vc];
      in_rem[vc] = in_rem[vc] - 8'd1;
    end
    it.tl = (in_rem[vc] == 8'd0);
    @(posedge clk);
    sq[vc].push_back(it);
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [31:0] hdr(int tag, int r, int c, int len_m1);
    return {8'(tag), 8'(r), 8'(c), 8'(len_m1)};
  endfunction

  task automatic drain();
    @(negedge clk);
    ordy = 5'h1f;
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Scoreboard monitor: samples 5 ns after the falling edge, before the next rise.
  initial begin
    forever begin
      int win;
      item_t e;
      @(negedge clk);
      #5;
      if (mon_en) begin
        win = -1;
        for (int k = 0; k < NV; k++) begin
          int i;
          i = sel ? (NV - 1 - k) : k;
          if (win < 0 && sq[i].size() > 0 && ordy[sq[i][0].dir]) win = i;
        end
        for (int v = 0; v < NV; v++)
          chk(m_rdy[v] == (sq[v].size() < DEPTH), "R1 in_ready", 32'(m_rdy[v]),
              32'(sq[v].size() < DEPTH));
        chk(m_v == (win >= 0), "R6 out_valid", 32'(m_v), 32'(win >= 0));
        if (win >= 0 && m_v) begin
          e = sq[win].pop_front();
          chk(m_vc == 2'(win), sel ? "R8 winner" : "R7 winner", 32'(m_vc), 32'(win));
          chk(m_d == e.d, "R2 data order", m_d, e.d);
          chk(m_dir == e.dir, e.hd ? (sel ? "R4 yx route" : "R3 xy route") : "R5 locked route",
              32'(m_dir), 32'(e.dir));
          chk({m_h, m_t} == {e.hd, e.tl}, "R5 head/tail marks", 32'({m_h, m_t}), 32'({e.hd, e.tl}));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sel = 1'b0;
    in_valid = 1'b0;
    in_vc = '0;
    in_head = 1'b0;
    in_data = '0;
    ordy = 5'h00;
    for (int v = 0; v < NV; v++) begin
      in_dirs[v] = 3'd0;
      in_rem[v] = 8'd0;
    end
    repeat (3) @(negedge clk);
    #5;
    // R9 reset state on both variants
    chk(!oa_v && !ob_v, "R9 out_valid in reset", 32'({oa_v, ob_v}), 32'd0);
    chk(ia_rdy == 3'b111, "R9 in_ready in reset", 32'(ia_rdy), 32'h7);
    chk(ib_rdy == 3'b111, "R9 in_ready in reset", 32'(ib_rdy), 32'h7);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R3: every destination of a 3x3 mesh, single-flit packets
    ordy = 5'h1f;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        send(0, 1'b1, hdr(r * 3 + c, r, c, 0));
    drain();

    // R1: channel 1 fills with no ready downstream, third flit waits
    ordy = 5'h00;
    fork
      begin
        send(1, 1'b1, hdr(8'h21, 1, 1, 0));
        send(1, 1'b1, hdr(8'h22, 1, 1, 0));
        send(1, 1'b1, hdr(8'h23, 1, 1, 0));
      end
      begin
        repeat (8) @(negedge clk);
        ordy = 5'h1f;
      end
    join
    drain();

    // R7: all channels loaded, then released together
    ordy = 5'h00;
    for (int v = NV - 1; v >= 0; v--) begin
      send(v, 1'b1, hdr(8'h40 + v * 2, 1, 1, 0));
      send(v, 1'b1, hdr(8'h41 + v * 2, 1, 1, 0));
    end
    drain();

    // R5: interleaved packets, body data that would decode elsewhere
    ordy = 5'b01000;
    fork
      begin
        send(0, 1'b1, hdr(8'h50, 1, 2, 3));
        send(1, 1'b1, hdr(8'h60, 2, 1, 2));
        send(0, 1'b0, 32'h0000_0000);
        send(1, 1'b0, 32'h0000_0200);
        send(0, 1'b0, 32'h0001_0100);
        send(1, 1'b0, 32'hFF00_0000);
        send(0, 1'b0, 32'h0002_0000);
        send(0, 1'b1, hdr(8'h70, 0, 0, 0));
      end
      begin
        repeat (14) @(negedge clk);
        ordy = 5'b01100;
        repeat (6) @(negedge clk);
        ordy = 5'h1f;
      end
    join
    drain();

    // R5: longest packet, 256 flits on channel 2
    ordy = 5'h1f;
    send(2, 1'b1, hdr(8'h80, 0, 1, 255));
    for (int n = 0; n < 255; n++) send(2, 1'b0, $urandom);
    drain();

    // R4 and R8: column-first, channel 0 lowest priority
    sel = 1'b1;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        send(1, 1'b1, hdr(8'h90 + r * 3 + c, r, c, 0));
    drain();
    ordy = 5'h00;
    for (int v = 0; v < NV; v++) begin
      send(v, 1'b1, hdr(8'hA0 + v * 2, 2, 0, 0));
      send(v, 1'b1, hdr(8'hA1 + v * 2, 2, 0, 0));
    end
    drain();

    finish_run();
  end
endmodule